// File: doc/BRIEF.md
# Battery Current Protection Fault Controller

This block guards a battery pack against three current faults. It takes a digitized sense-resistor sample every clock and checks it against three limits: discharge overload, discharge short circuit and charge short circuit. Each limit has its own threshold code and its own blanking-delay code. A condition that is still present when its delay has run out latches a fault flag. Any latched flag turns off both the charge and the discharge FET drives.

The delays are counted on a 1 µs timebase tick. Overload delays use a 2 ms grid that starts at 1 ms. Short-circuit delays use a 61 µs grid that starts at zero. One scale bit halves every threshold and every threshold step, for use with a sense resistor of twice the value. The drives also stay off during reset and whenever the logic supply is reported unhealthy. Flags stay set until firmware pulses the clear input after the fault has gone away.

The configuration codes come from registers outside this block and are held stable by them. Code zero gives the power-on settings: 50 mV and 1 ms for overload, and 100 mV with no delay for the short-circuit limits.

Top module: `batt_prot_ctrl`

## Requirements
- R1: The sense sample is signed with an LSB of 0.5 mV; positive means discharge. With the scale bit 0, the overload condition is a sample strictly greater than 100 + 10·code LSB (50 mV + 5 mV per code, code 0..31).
- R2: With the scale bit 0, the discharge short-circuit condition is a sample strictly greater than 200 + 50·code LSB (100 mV + 25 mV per code). The charge short-circuit condition is the negated sample strictly greater than 200 + 50·code LSB.
- R3: With the scale bit 1, every threshold is half its unscaled value: 50 + 5·code LSB for overload and 100 + 25·code LSB for both short-circuit limits.
- R4: The overload delay is 1000 + 2000·code ticks. Its flag sets on the clock edge after the one at which the counter, advanced by one per tick while the condition holds, reaches that value.
- R5: Each short-circuit delay is 61·code ticks. With code 0, the flag sets on the first clock edge at which the sample is over the threshold.
- R6: A detector's counter returns to zero in any cycle its condition is absent. It advances only in cycles where the tick is high.
- R7: While any fault flag is set, the charge and discharge drives are low.
- R8: During reset, in the first cycle after reset, and whenever supply-good is low, the charge, discharge and precharge drives are all low.
- R9: Flags are sticky. A clear pulse drops only the flags whose condition is absent in that cycle. The drives return high once no flag remains set and the supply is good.
- R10: Faults that qualify in the same cycle set their flags on the same clock edge.
- R11: The precharge drive (active low, low = on) is high only while the charge drive is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| sense | input | SNS_W | Signed sense sample, 0.5 mV LSB, positive = discharge |
| ol_thr_code | input | 5 | Overload threshold code |
| ol_dly_code | input | 4 | Overload delay code |
| scd_thr_code | input | 4 | Discharge short-circuit threshold code |
| scd_dly_code | input | 4 | Discharge short-circuit delay code |
| scc_thr_code | input | 4 | Charge short-circuit threshold code |
| scc_dly_code | input | 4 | Charge short-circuit delay code |
| half_scale | input | 1 | Halve all thresholds |
| supply_good | input | 1 | Logic supply healthy |
| clr_fault | input | 1 | One-cycle clear request for latched flags |
| chg_drv | output | 1 | Charge FET drive, high = on |
| dsg_drv | output | 1 | Discharge FET drive, high = on |
| pchg_drv | output | 1 | Precharge FET drive, low = on |
| flt_ol | output | 1 | Latched overload flag |
| flt_scd | output | 1 | Latched discharge short-circuit flag |
| flt_scc | output | 1 | Latched charge short-circuit flag |

## Verification
The overload and the discharge short circuit can qualify in the same cycle. The overload delay cannot be a multiple of the 61 µs grid, so the bench arranges the overlap another way. It holds a sample above the overload limit but below the short-circuit limit for exactly 1000 ticks. In the cycle the overload counter reaches its limit, it raises the sample above the short-circuit limit, which is set to zero delay. The check is that both flags appear on the same clock edge and neither appears one edge early. A reference model checked on every clock confirms this at every other edge too.

// File: rtl/prot_pkg.sv
package prot_pkg;

  localparam int NDET      = 3;
  localparam int OL_CODE_W = 5;
  localparam int SC_CODE_W = 4;

  // detector slots, in the order of the flag vector
  typedef enum int unsigned {
    DET_OL  = 0,
    DET_SCD = 1,
    DET_SCC = 2
  } det_e;

  // thresholds in sense LSBs (0.5 mV) at full scale
  localparam int OL_BASE_LSB = 100;
  localparam int OL_STEP_LSB = 10;
  localparam int SC_BASE_LSB = 200;
  localparam int SC_STEP_LSB = 50;

  // delays in 1 us ticks
  localparam int OL_DLY_BASE = 1000;
  localparam int OL_DLY_STEP = 2000;
  localparam int SC_DLY_STEP = 61;

  function automatic int ol_thr_lsb(input logic [OL_CODE_W-1:0] code, input logic half);
    int full;
    full = OL_BASE_LSB + OL_STEP_LSB * int'(code);
    return half ? full / 2 : full;
  endfunction

  function automatic int sc_thr_lsb(input logic [SC_CODE_W-1:0] code, input logic half);
    int full;
    full = SC_BASE_LSB + SC_STEP_LSB * int'(code);
    return half ? full / 2 : full;
  endfunction

  function automatic int ol_dly_ticks(input logic [SC_CODE_W-1:0] code);
    return OL_DLY_BASE + OL_DLY_STEP * int'(code);
  endfunction

  function automatic int sc_dly_ticks(input logic [SC_CODE_W-1:0] code);
    return SC_DLY_STEP * int'(code);
  endfunction

endpackage

// File: rtl/prot_dly_det.sv
// Blanking timer of one detector: counts ticks while the condition holds,
// qualifies once the programmed number of ticks has been reached.
module prot_dly_det #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cond,
  input  logic [CNT_W-1:0] limit,
  output logic             qual
);

  logic [CNT_W-1:0] cnt;
  logic             reached;

  assign reached = (cnt >= limit);
  assign qual    = cond & reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!cond) begin
      cnt <= '0;
    end else if (tick && !reached) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/prot_flag_bank.sv
// Sticky fault flags: set on qualify, cleared by a clear pulse only when the
// matching condition is absent.
module prot_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] qual,
  input  logic [N-1:0] cond,
  output logic [N-1:0] flags
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic f;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f <= 1'b0;
      end else if (qual[g]) begin
        f <= 1'b1;
      end else if (clr && !cond[g]) begin
        f <= 1'b0;
      end
    end
    assign flags[g] = f;
  end

endmodule

// File: rtl/batt_prot_ctrl.sv
module batt_prot_ctrl
  import prot_pkg::*;
#(
  parameter int SNS_W = 16,
  parameter int CNT_W = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_1us,
  input  logic signed [SNS_W-1:0]    sense,
  input  logic [OL_CODE_W-1:0]       ol_thr_code,
  input  logic [SC_CODE_W-1:0]       ol_dly_code,
  input  logic [SC_CODE_W-1:0]       scd_thr_code,
  input  logic [SC_CODE_W-1:0]       scd_dly_code,
  input  logic [SC_CODE_W-1:0]       scc_thr_code,
  input  logic [SC_CODE_W-1:0]       scc_dly_code,
  input  logic                       half_scale,
  input  logic                       supply_good,
  input  logic                       clr_fault,
  output logic                       chg_drv,
  output logic                       dsg_drv,
  output logic                       pchg_drv,
  output logic                       flt_ol,
  output logic                       flt_scd,
  output logic                       flt_scc
);

  localparam int EXT_W = SNS_W + 1;

  // sign-extended so the negation of the most negative sample cannot wrap
  logic signed [EXT_W-1:0] dsg_val;
  logic signed [EXT_W-1:0] chg_val;

  logic ol_cond;
  logic scd_cond;
  logic scc_cond;

  logic [NDET-1:0]            cond_vec;
  logic [NDET-1:0]            qual_vec;
  logic [NDET-1:0]            flag_vec;
  logic [NDET-1:0][CNT_W-1:0] dly_vec;

  logic run_q;
  logic drv_on;

  assign dsg_val = {sense[SNS_W-1], sense};
  assign chg_val = -dsg_val;

  assign ol_cond  = int'(dsg_val) > ol_thr_lsb(ol_thr_code, half_scale);
  assign scd_cond = int'(dsg_val) > sc_thr_lsb(scd_thr_code, half_scale);
  assign scc_cond = int'(chg_val) > sc_thr_lsb(scc_thr_code, half_scale);

  assign cond_vec[DET_OL]  = ol_cond;
  assign cond_vec[DET_SCD] = scd_cond;
  assign cond_vec[DET_SCC] = scc_cond;

  assign dly_vec[DET_OL]  = CNT_W'(ol_dly_ticks(ol_dly_code));
  assign dly_vec[DET_SCD] = CNT_W'(sc_dly_ticks(scd_dly_code));
  assign dly_vec[DET_SCC] = CNT_W'(sc_dly_ticks(scc_dly_code));

  for (genvar g = 0; g < NDET; g++) begin : g_det
    prot_dly_det #(
      .CNT_W(CNT_W)
    ) u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_1us),
      .cond (cond_vec[g]),
      .limit(dly_vec[g]),
      .qual (qual_vec[g])
    );
  end

  prot_flag_bank #(
    .N(NDET)
  ) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_fault),
    .qual (qual_vec),
    .cond (cond_vec),
    .flags(flag_vec)
  );

  // drives stay off for the first cycle out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
    end
  end

  assign drv_on   = run_q & supply_good & ~(|flag_vec);
  assign chg_drv  = drv_on;
  assign dsg_drv  = drv_on;
  assign pchg_drv = drv_on;

  assign flt_ol  = flag_vec[DET_OL];
  assign flt_scd = flag_vec[DET_SCD];
  assign flt_scc = flag_vec[DET_SCC];

endmodule

// File: rtl/prot_chk.sv
module prot_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         supply_good,
  input logic         clr_fault,
  input logic         chg_drv,
  input logic         dsg_drv,
  input logic         pchg_drv,
  input logic [3:0]   scd_dly_code,
  input logic [N-1:0] cond_vec,
  input logic [N-1:0] qual_vec,
  input logic [N-1:0] flag_vec
);

  p_drv_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_vec) |-> (!chg_drv && !dsg_drv));

  p_supply_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |-> (!chg_drv && !dsg_drv && !pchg_drv));

  p_pchg_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pchg_drv |-> chg_drv);

  p_zero_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_vec[1] && scd_dly_code == 4'd0) |=> flag_vec[1]);

  p_same_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_vec[0] && qual_vec[1]) |=> (flag_vec[0] && flag_vec[1]));

  for (genvar g = 0; g < N; g++) begin : g_flag_chk
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_vec[g] && !clr_fault) |=> flag_vec[g]);

    p_clr_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_vec[g] && cond_vec[g]) |=> flag_vec[g]);

    p_rise_needs_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_vec[g]) |-> $past(cond_vec[g]));
  end

endmodule

bind batt_prot_ctrl prot_chk #(.N(prot_pkg::NDET)) u_prot_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_good (supply_good),
  .clr_fault   (clr_fault),
  .chg_drv     (chg_drv),
  .dsg_drv     (dsg_drv),
  .pchg_drv    (pchg_drv),
  .scd_dly_code(scd_dly_code),
  .cond_vec    (cond_vec),
  .qual_vec    (qual_vec),
  .flag_vec    (flag_vec)
);

// File: tb/batt_prot_ctrl_test.sv
module batt_prot_ctrl_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               tick = 1'b1;
  logic signed [15:0] sense = '0;
  logic [4:0]         ol_thr = '0;
  logic [3:0]         ol_dly = '0;
  logic [3:0]         scd_thr = '0;
  logic [3:0]         scd_dly = '0;
  logic [3:0]         scc_thr = '0;
  logic [3:0]         scc_dly = '0;
  logic               half = 1'b0;
  logic               sup = 1'b1;
  logic               clr = 1'b0;

  logic chg, dsg, pchg, f_ol, f_scd, f_scc;

  batt_prot_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick), .sense(sense),
    .ol_thr_code(ol_thr), .ol_dly_code(ol_dly),
    .scd_thr_code(scd_thr), .scd_dly_code(scd_dly),
    .scc_thr_code(scc_thr), .scc_dly_code(scc_dly),
    .half_scale(half), .supply_good(sup), .clr_fault(clr),
    .chg_drv(chg), .dsg_drv(dsg), .pchg_drv(pchg),
    .flt_ol(f_ol), .flt_scd(f_scd), .flt_scc(f_scc)
  );

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt [3];
  bit m_flag [3];
  bit m_run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0;
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_flag[i] = 0; end
    end else begin
      int v [3];
      int th [3];
      int dl [3];
      bit c, q;
      v[0] = sense; v[1] = sense; v[2] = -int'(sense);
      th[0] = half ? 50 + 5 * ol_thr : 100 + 10 * ol_thr;
      th[1] = half ? 100 + 25 * scd_thr : 200 + 50 * scd_thr;
      th[2] = half ? 100 + 25 * scc_thr : 200 + 50 * scc_thr;
      dl[0] = 1000 + 2000 * ol_dly;
      dl[1] = 61 * scd_dly;
      dl[2] = 61 * scc_dly;
      for (int i = 0; i < 3; i++) begin
        c = v[i] > th[i];
        q = c && (m_cnt[i] >= dl[i]);
        if (q) m_flag[i] = 1;
        else if (clr && !c) m_flag[i] = 0;
        if (!c) m_cnt[i] = 0;
        else if (tick && m_cnt[i] < dl[i]) m_cnt[i]++;
      end
      m_run = 1;
    end
  end

  // compare on every clock, away from both edges
  always begin
    @(posedge clk);
    #1;
    if (!done) begin
      bit on;
      on = m_run && sup && !(m_flag[0] || m_flag[1] || m_flag[2]);
      chk("MODEL flt_ol", f_ol, m_flag[0]);
      chk("MODEL flt_scd", f_scd, m_flag[1]);
      chk("MODEL flt_scc", f_scc, m_flag[2]);
      chk("MODEL chg_drv", chg, on);
      chk("MODEL dsg_drv", dsg, on);
      chk("MODEL pchg_drv", pchg, on);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all;
    sense = '0;
    nclk(1);
    clr = 1'b1;
    nclk(1);
    clr = 1'b0;
    nclk(1);
  endtask

  initial begin
    // reset state
    nclk(3);
    chk("R8 chg in reset", chg, 1'b0);
    chk("R8 dsg in reset", dsg, 1'b0);
    chk("R8 pchg in reset", pchg, 1'b0);
    chk("R9 flags clear in reset", f_ol | f_scd | f_scc, 1'b0);
    rst_n = 1'b1;
    nclk(1);
    chk("R8 drives on after reset", chg & dsg, 1'b1);
    chk("R11 pchg off while chg on", pchg, 1'b1);

    // R1/R4: overload at threshold never trips; one LSB above trips after 1000 ticks
    scd_thr = 4'd15;
    sense = 16'sd100;
    nclk(1100);
    chk("R1 at threshold no overload", f_ol, 1'b0);
    sense = 16'sd101;
    nclk(1000);
    chk("R4 overload not before 1000 ticks", f_ol, 1'b0);
    nclk(1);
    chk("R4 overload at 1000 ticks", f_ol, 1'b1);
    chk("R7 chg off on fault", chg, 1'b0);
    chk("R7 dsg off on fault", dsg, 1'b0);
    chk("R11 pchg on when chg off", pchg, 1'b0);

    // R9: clear ignored while condition present
    clr = 1'b1;
    nclk(1);
    clr = 1'b0;
    nclk(1);
    chk("R9 clear blocked by present fault", f_ol, 1'b1);
    chk("R9 drives still off", chg, 1'b0);
    clear_all;
    chk("R9 flag cleared", f_ol, 1'b0);
    chk("R9 drives re-enabled", chg & dsg, 1'b1);

    // R4: code 1 = 3000 ticks
    ol_dly = 4'd1;
    sense = 16'sd300;
    nclk(3000);
    chk("R4 code1 not before 3000", f_ol, 1'b0);
    nclk(1);
    chk("R4 code1 at 3000", f_ol, 1'b1);
    clear_all;
    ol_dly = 4'd0;

    // R2/R5: discharge short, code 0 threshold 200 LSB, zero delay
    scd_thr = 4'd0;
    scd_dly = 4'd0;
    sense = 16'sd200;
    nclk(5);
    chk("R2 scd at threshold no trip", f_scd, 1'b0);
    sense = 16'sd201;
    nclk(1);
    chk("R5 scd zero delay first sample", f_scd, 1'b1);
    chk("R5 overload not yet", f_ol, 1'b0);
    clear_all;
    chk("R9 scd cleared", f_scd, 1'b0);

    // R2/R5: charge short, 61 ticks, negative sample
    scc_thr = 4'd0;
    scc_dly = 4'd1;
    sense = -16'sd201;
    nclk(61);
    chk("R5 scc not before 61 ticks", f_scc, 1'b0);
    nclk(1);
    chk("R2 scc trips on charge current", f_scc, 1'b1);
    chk("R7 dsg off on charge fault", dsg, 1'b0);
    chk("R1 no overload on charge current", f_ol, 1'b0);
    clear_all;

    // R3: halved thresholds
    half = 1'b1;
    sense = 16'sd100;
    nclk(3);
    chk("R3 halved scd at threshold", f_scd, 1'b0);
    sense = 16'sd101;
    nclk(1);
    chk("R3 halved scd trips", f_scd, 1'b1);
    clear_all;
    sense = -16'sd101;
    nclk(62);
    chk("R3 halved scc trips", f_scc, 1'b1);
    clear_all;
    half = 1'b0;

    // R6: dropout restarts counter; tick gating
    scd_thr = 4'd15;
    sense = 16'sd101;
    nclk(900);
    sense = 16'sd0;
    nclk(1);
    sense = 16'sd101;
    nclk(900);
    chk("R6 dropout restarted count", f_ol, 1'b0);
    tick = 1'b0;
    nclk(1200);
    chk("R6 no count without tick", f_ol, 1'b0);
    tick = 1'b1;
    nclk(100);
    chk("R6 count resumes held value", f_ol, 1'b0);
    nclk(1);
    chk("R6 trips after remaining ticks", f_ol, 1'b1);
    clear_all;

    // R10: overload and discharge short qualify on the same edge
    scd_thr = 4'd0;
    scd_dly = 4'd0;
    sense = 16'sd150;
    nclk(1000);
    chk("R10 no flag one edge early", f_ol | f_scd, 1'b0);
    sense = 16'sd250;
    nclk(1);
    chk("R10 overload set together", f_ol, 1'b1);
    chk("R10 scd set together", f_scd, 1'b1);
    sense = 16'sd0;
    nclk(1);
    chk("R9 flags hold without clear", f_ol & f_scd, 1'b1);
    clear_all;
    chk("R9 both cleared", f_ol | f_scd, 1'b0);

    // R8: supply loss
    sup = 1'b0;
    #1;
    chk("R8 chg off supply low", chg, 1'b0);
    chk("R8 dsg off supply low", dsg, 1'b0);
    chk("R8 pchg on supply low", pchg, 1'b0);
    nclk(2);
    sup = 1'b1;
    #1;
    chk("R8 drives back with supply", chg & dsg & pchg, 1'b1);
    nclk(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule